// File: doc/BRIEF.md
# Timestamp Snapshot Byte Serializer

The block takes a picture of a free-running time value (a 32-bit seconds count and a 20-bit microseconds count) when a one-cycle request arrives, and sends that picture out as a fixed eight-byte stream. The time value belongs to one clock domain, the time clock. The request and the byte stream belong to a second domain, the stream clock. The two clocks may be one and the same or unrelated.

A request in the stream domain toggles a flag. That flag is synchronised into the time domain, and the resulting edge captures the time value into a holding register. The same edge toggles an acknowledge flag back towards the stream domain. When the acknowledge arrives, the stream side raises a one-cycle pre-strobe and then puts out the eight bytes on the following eight stream clocks. The holding register does not change while a message is in flight, because no new capture can be requested until the last byte has left.

Top module: `ts_snap_serializer`

## Requirements
- R1: While reset is held and after its release, with no request, `pre_stb_o` is 0 and `data_o` is 0x00.
- R2: A message is a one-cycle `pre_stb_o` pulse followed by eight data bytes on the eight stream clocks that directly follow it.
- R3: Message bytes 0 to 3 carry the captured seconds, least significant byte first.
- R4: Message bytes 4 to 6 carry the captured microseconds, least significant byte first. The upper four bits of byte 6 are 0.
- R5: Message byte 7 is always 0x00.
- R6: With the two clocks the same, `pre_stb_o` is high after the 6th rising edge following the edge that samples `snap_i`. The captured value is the one present on `sec_i`/`usec_i` at the 3rd rising edge after that sampling edge.
- R7: A request is ignored if it is sampled from the edge that accepts a request up to and including the edge that puts out byte 7. A request sampled on the next edge is accepted.
- R8: `data_o` is 0x00 in every cycle that does not carry a message byte.
- R9: The captured value stays constant from its capture until the next accepted request reaches the time domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Asynchronous active-high reset for both domains |
| tclk | input | 1 | Time-domain clock |
| sec_i | input | 32 | Current seconds, in the time domain |
| usec_i | input | 20 | Current microseconds, in the time domain |
| sclk | input | 1 | Stream-domain clock |
| snap_i | input | 1 | One-cycle snapshot request, in the stream domain |
| pre_stb_o | output | 1 | High one cycle before the first message byte |
| data_o | output | 8 | Serialized message byte |

## Verification
The case hardest to reach is a request that lands exactly at the end of the busy window. A request on the edge that emits byte 7 must be dropped, and a request one edge later must start a new message back to back with the previous one. The stimulus places requests at those exact offsets from an accepted one, and adds requests in the middle of a message. It then runs a long pseudo-random request pattern against a behavioural model that predicts every output byte. The time inputs change on every clock, so a capture taken one cycle early or late shows up as a wrong byte.

// File: rtl/ts_snap_pkg.sv
package ts_snap_pkg;
    parameter int SEC_W       = 32;
    parameter int USEC_W      = 20;
    parameter int FIELD_W     = 32;
    parameter int SYNC_STAGES = 2;
    localparam int TIME_W    = SEC_W + USEC_W;
    localparam int MSG_W     = 2 * FIELD_W;
    localparam int MSG_BYTES = MSG_W / 8;
    localparam int IDX_W     = $clog2(MSG_BYTES);

    typedef struct packed {
        logic             busy;
        logic             sending;
        logic [IDX_W-1:0] idx;
        logic             stb;
        logic [7:0]       data;
    } seq_state_t;
endpackage

// File: rtl/ts_pulse_xfer.sv
module ts_pulse_xfer #(
    parameter int STAGES = 2
) (
    input  logic rst,
    input  logic src_clk,
    input  logic pulse_i,
    input  logic dst_clk,
    output logic pulse_o
);
    logic              tgl_d, tgl_q;
    logic [STAGES-1:0] sync_d, sync_q;
    logic              last_d, last_q;

    always_comb begin
        tgl_d  = tgl_q ^ pulse_i;
        sync_d = {sync_q[STAGES-2:0], tgl_q};
        last_d = sync_q[STAGES-1];
    end

    always_ff @(posedge src_clk or posedge rst) begin
        if (rst) tgl_q <= 1'b0;
        else     tgl_q <= tgl_d;
    end

    always_ff @(posedge dst_clk or posedge rst) begin
        if (rst) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= sync_d;
            last_q <= last_d;
        end
    end

    assign pulse_o = sync_q[STAGES-1] ^ last_q;

    // R7
    pulse_single_chk: assert property (@(posedge dst_clk) disable iff (rst)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/ts_capture_hold.sv
module ts_capture_hold
    import ts_snap_pkg::*;
(
    input  logic              rst,
    input  logic              clk,
    input  logic              cap_i,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [USEC_W-1:0] usec_i,
    output logic [TIME_W-1:0] hold_o
);
    logic [TIME_W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (cap_i) hold_d = {usec_i, sec_i};
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) hold_q <= '0;
        else     hold_q <= hold_d;
    end

    assign hold_o = hold_q;

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(hold_q));
endmodule

// File: rtl/ts_byte_seq.sv
module ts_byte_seq
    import ts_snap_pkg::*;
(
    input  logic              rst,
    input  logic              clk,
    input  logic              snap_i,
    input  logic              ack_i,
    input  logic [TIME_W-1:0] hold_i,
    output logic              issue_o,
    output logic              pre_stb_o,
    output logic [7:0]        data_o
);
    seq_state_t        st_d, st_q;
    logic [MSG_W-1:0]  msg;

    assign msg     = {{(FIELD_W-USEC_W){1'b0}}, hold_i[TIME_W-1:SEC_W],
                      {(FIELD_W-SEC_W){1'b0}}, hold_i[SEC_W-1:0]};
    assign issue_o = snap_i && !st_q.busy;

    always_comb begin
        st_d      = st_q;
        st_d.stb  = 1'b0;
        st_d.data = 8'h00;
        if (issue_o) st_d.busy = 1'b1;
        if (ack_i && st_q.busy && !st_q.sending) begin
            st_d.stb     = 1'b1;
            st_d.sending = 1'b1;
            st_d.idx     = '0;
        end
        if (st_q.sending) begin
            st_d.data = msg[st_q.idx*8 +: 8];
            st_d.idx  = st_q.idx + 1'b1;
            if (st_q.idx == IDX_W'(MSG_BYTES-1)) begin
                st_d.sending = 1'b0;
                st_d.busy    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pre_stb_o = st_q.stb;
    assign data_o    = st_q.data;

    // R2
    stb_then_send_chk: assert property (@(posedge clk) disable iff (rst)
        pre_stb_o |=> (!pre_stb_o && st_q.sending));
    // R7
    ack_when_waiting_chk: assert property (@(posedge clk) disable iff (rst)
        ack_i |-> (st_q.busy && !st_q.sending));
    // R5
    last_byte_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.sending && st_q.idx == IDX_W'(MSG_BYTES-1)) |=> (data_o == 8'h00));
    // R8
    idle_data_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.sending |=> (data_o == 8'h00));
endmodule

// File: rtl/ts_snap_serializer.sv
module ts_snap_serializer
    import ts_snap_pkg::*;
(
    input  logic              rst,
    input  logic              tclk,
    input  logic [SEC_W-1:0]  sec_i,
    input  logic [USEC_W-1:0] usec_i,
    input  logic              sclk,
    input  logic              snap_i,
    output logic              pre_stb_o,
    output logic [7:0]        data_o
);
    logic              issue;
    logic              cap_pulse;
    logic              ack_pulse;
    logic [TIME_W-1:0] hold;

    ts_pulse_xfer #(.STAGES(SYNC_STAGES)) u_req_xfer (
        .rst(rst), .src_clk(sclk), .pulse_i(issue),
        .dst_clk(tclk), .pulse_o(cap_pulse)
    );

    ts_capture_hold u_hold (
        .rst(rst), .clk(tclk), .cap_i(cap_pulse),
        .sec_i(sec_i), .usec_i(usec_i), .hold_o(hold)
    );

    ts_pulse_xfer #(.STAGES(SYNC_STAGES)) u_ack_xfer (
        .rst(rst), .src_clk(tclk), .pulse_i(cap_pulse),
        .dst_clk(sclk), .pulse_o(ack_pulse)
    );

    ts_byte_seq u_seq (
        .rst(rst), .clk(sclk), .snap_i(snap_i), .ack_i(ack_pulse),
        .hold_i(hold), .issue_o(issue), .pre_stb_o(pre_stb_o), .data_o(data_o)
    );
endmodule

// File: tb/tb_ts_snap_serializer.sv
`timescale 1ns/1ps
module tb_ts_snap_serializer;
    localparam int N = 3000;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] sec;
    logic [19:0] usec;
    logic        snap;
    logic        pre_stb;
    logic [7:0]  data;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic       exp_stb  [0:N+40];
    logic [7:0] exp_data [0:N+40];
    logic [2:0] exp_tag  [0:N+40];

    always #2.5 clk = ~clk;

    ts_snap_serializer dut (
        .rst(rst), .tclk(clk), .sec_i(sec), .usec_i(usec),
        .sclk(clk), .snap_i(snap), .pre_stb_o(pre_stb), .data_o(data)
    );

    function automatic logic [31:0] fsec(int n);
        return 32'(n) * 32'h9E3779B1 ^ 32'h5A00C3F0;
    endfunction
    function automatic logic [19:0] fusec(int n);
        return 20'(n * 347 + 5);
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        int lcg = 12345;
        int free_at = 0;
        logic [63:0] msg;
        for (int i = 0; i <= N + 40; i++) begin
            exp_stb[i] = 1'b0; exp_data[i] = 8'h00; exp_tag[i] = 3'd0;
        end
        rst = 1'b1; snap = 1'b0; sec = '0; usec = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset stb", {7'b0, pre_stb}, 8'h00);
        chk("R1 reset data", data, 8'h00);
        rst = 1'b0;
        for (int n = 1; n <= N; n++) begin
            @(negedge clk);
            if (exp_stb[n]) chk("R2 R6 pre-strobe", {7'b0, pre_stb}, 8'h01);
            else            chk("R2 R7 no pre-strobe", {7'b0, pre_stb}, 8'h00);
            case (exp_tag[n])
                3'd1: chk("R3 seconds byte", data, exp_data[n]);
                3'd2: chk("R4 microseconds byte", data, exp_data[n]);
                3'd3: chk("R5 top byte", data, exp_data[n]);
                default: chk("R1 R8 idle data", data, exp_data[n]);
            endcase
            sec  = fsec(n);
            usec = fusec(n);
            lcg  = (lcg * 1103515245 + 12345) & 32'h7fffffff;
            if (n < 60)
                snap = (n == 5) || (n == 6) || (n == 19) || (n == 20) ||
                       (n == 28) || (n == 35) || (n == 42);
            else
                snap = n < N - 30 && ((lcg >> 8) % 6 == 0);
            if (snap && n >= free_at) begin
                free_at = n + 15;
                msg = {12'h000, fusec(n + 3), fsec(n + 3)};
                exp_stb[n + 7] = 1'b1;
                for (int b = 0; b < 8; b++) begin
                    exp_data[n + 8 + b] = msg[b*8 +: 8];
                    exp_tag[n + 8 + b]  = (b < 4) ? 3'd1 : (b < 7) ? 3'd2 : 3'd3;
                end
            end
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (N + 1000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule